// File: doc/BRIEF.md
# Audio FIFO Status and Interrupt Unit

This unit sits beside the transmit and receive sample FIFOs of a serial audio controller (I2S or left-justified framing). It watches the occupancy counts and the push and pop strobes of both FIFOs and turns them into one read-only 32-bit status word. From that word it derives a masked interrupt line and two DMA service requests. The FIFO storage, the serial shifter and the bit-clock logic live elsewhere and only feed this unit.

Every status field is registered, so the word shows FIFO state as of the previous clock edge. Two error flags latch and stay set until software clears them through a write-one-to-clear strobe. Two service requests follow the FIFO levels against programmable thresholds. Both requests are forced low while the controller is disabled. The DMA requests copy the service requests without the interrupt mask, so DMA transfers run whatever the mask holds.

Top module: `audio_fifo_status`

## Requirements
- R1: After a synchronous active-low reset, the status word reads 0x0000_0001, and `irq_o`, `rx_dma_req_o` and `tx_dma_req_o` are all 0.
- R2: One clock after the inputs are applied, word bits 15:12 hold the receive count modulo 16 and bits 11:8 hold the transmit count modulo 16. A full 16-entry FIFO therefore reads as level 0. Bits 31:16 and bit 7 always read 0.
- R3: Bit 1 is 1 when the receive count is non-zero. Bit 0 is 1 when the transmit count is below 16. Neither bit depends on the enable.
- R4: Bit 6 (receive overrun) sets one clock after a cycle in which `rx_push_ser_i` is high, the receive count is 16 and `rx_pop_bus_i` is low. Once set, it stays set until it is cleared.
- R5: Bit 5 (transmit underrun) sets one clock after a cycle in which `tx_pop_ser_i` is high, the transmit count is 0 and `tx_push_bus_i` is low. Once set, it stays set until it is cleared.
- R6: When `clr_we_i` is high, `clr_bits_i[1]` clears bit 6 and `clr_bits_i[0]` clears bit 5. A flag whose clear bit is 0 keeps its value. When a set event and a clear for the same flag fall in the same cycle, the flag ends up 1.
- R7: Bit 4 (receive request) is 1 exactly when the enable is high and the receive count is at least `rx_thresh_i` + 1.
- R8: Bit 3 (transmit request) is 1 exactly when the enable is high and the transmit count is at most `tx_thresh_i`.
- R9: Bit 2 (busy) is 1 exactly when the enable is high and `frame_active_i` is high.
- R10: `irq_o` is the OR of (mask[3] AND bit 6), (mask[2] AND bit 5), (mask[1] AND bit 4) and (mask[0] AND bit 3). It is formed from the registered word and the current mask, with no clock delay.
- R11: `rx_dma_req_o` equals bit 4 and `tx_dma_req_o` equals bit 3, whatever the interrupt mask holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable_i | input | 1 | Global controller enable |
| frame_active_i | input | 1 | A serial frame is being shifted |
| rx_count_i | input | 5 | Receive FIFO occupancy, 0 to 16 |
| tx_count_i | input | 5 | Transmit FIFO occupancy, 0 to 16 |
| rx_push_ser_i | input | 1 | Serial side writes a received sample |
| rx_pop_bus_i | input | 1 | Bus side reads a received sample |
| tx_push_bus_i | input | 1 | Bus side writes a sample to send |
| tx_pop_ser_i | input | 1 | Serial side takes a sample to send |
| rx_thresh_i | input | 4 | Receive request threshold |
| tx_thresh_i | input | 4 | Transmit request threshold |
| irq_mask_i | input | 4 | Interrupt mask: [3] overrun, [2] underrun, [1] rx request, [0] tx request |
| clr_we_i | input | 1 | Interrupt-clear write strobe |
| clr_bits_i | input | 2 | Clear data: [1] overrun, [0] underrun |
| status_o | output | 32 | Registered status word |
| irq_o | output | 1 | Masked interrupt |
| rx_dma_req_o | output | 1 | Receive DMA service request |
| tx_dma_req_o | output | 1 | Transmit DMA service request |

## Verification
The hardest case to reach is the pair of flag events that share one cycle with an opposing strobe. One is a serial push into a full receive FIFO while the bus pops in that same cycle. The other is a set event landing on the same edge as a clear of that flag. The stimulus holds the counts at their limits and raises the competing strobes in one cycle. It then reads the flag on the next cycle and again several cycles later. The threshold compares are swept over every count and threshold pair, with the enable both low and high.

// File: rtl/afs_pkg.sv
// Package afs_pkg: bit positions of the audio FIFO status word.
// Assumes a 32-bit word with 4-bit level fields.
package afs_pkg;
    localparam int STW      = 32;
    localparam int LVL_W    = 4;
    localparam int B_TXNF   = 0;
    localparam int B_RXNE   = 1;
    localparam int B_BUSY   = 2;
    localparam int B_TXREQ  = 3;
    localparam int B_RXREQ  = 4;
    localparam int B_UNDER  = 5;
    localparam int B_OVER   = 6;
    localparam int TXLVL_LO = 8;
    localparam int RXLVL_LO = 12;
endpackage

// File: rtl/afs_sticky.sv
// Module afs_sticky: one error flag that sets on an event and clears on a strobe.
// Assumes the set and clear inputs are single-cycle pulses in the clk domain.
// When set and clear arrive together, set wins.
module afs_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Latch the event, release only on an explicit clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_o <= 1'b0;
        else if (set_i)  flag_o <= 1'b1;
        else if (clr_i)  flag_o <= 1'b0;
    end

    // R6: an event always wins over a clear in the same cycle
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    // R4 / R5: the flag holds without a clear
    a_r4_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/afs_threshold.sv
// Module afs_threshold: compares an occupancy count against a threshold.
// ABOVE=1 gives a request at count >= thresh+1 (receive side).
// ABOVE=0 gives a request at count <= thresh (transmit side).
// Assumes TH_W < CNT_W, so thresh+1 cannot overflow.
module afs_threshold #(
    parameter int CNT_W = 5,
    parameter int TH_W  = 4,
    parameter bit ABOVE = 1'b1
) (
    input  logic             enable_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [TH_W-1:0]  thresh_i,
    output logic             req_o
);
    logic [CNT_W-1:0] th_ext;
    logic             hit;

    // Widen the threshold to the count width.
    always_comb th_ext = CNT_W'(thresh_i);

    generate
        if (ABOVE) begin : g_above
            // Request once occupancy passes the threshold.
            always_comb hit = (count_i >= (th_ext + CNT_W'(1)));
        end else begin : g_below
            // Request while occupancy is at or under the threshold.
            always_comb hit = (count_i <= th_ext);
        end
    endgenerate

    // Gate the request with the enable.
    always_comb req_o = enable_i && hit;
endmodule

// File: rtl/audio_fifo_status.sv
// Module audio_fifo_status: status word, masked interrupt and DMA requests
// for the sample FIFOs of a serial audio controller.
// Assumes the counts are 0..DEPTH and the strobes are clk-synchronous pulses.
// Every field is registered, so the word lags its inputs by one clock.
module audio_fifo_status #(
    parameter int DEPTH = 16,
    parameter int TH_W  = 4,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              frame_active_i,
    input  logic [CNT_W-1:0]  rx_count_i,
    input  logic [CNT_W-1:0]  tx_count_i,
    input  logic              rx_push_ser_i,
    input  logic              rx_pop_bus_i,
    input  logic              tx_push_bus_i,
    input  logic              tx_pop_ser_i,
    input  logic [TH_W-1:0]   rx_thresh_i,
    input  logic [TH_W-1:0]   tx_thresh_i,
    input  logic [3:0]        irq_mask_i,
    input  logic              clr_we_i,
    input  logic [1:0]        clr_bits_i,
    output logic [31:0]       status_o,
    output logic              irq_o,
    output logic              rx_dma_req_o,
    output logic              tx_dma_req_o
);
    import afs_pkg::*;

    localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] EMPTY_CNT = '0;
    localparam int               NERR      = 2;

    logic [NERR-1:0] err_evt;
    logic [NERR-1:0] err_clr;
    logic [NERR-1:0] err_flag;
    logic            rx_req_d;
    logic            tx_req_d;
    logic [STW-1:0]  base_d;
    logic [STW-1:0]  base_q;

    // Error events: index 1 is overrun, index 0 is underrun.
    // A same-cycle opposite-side strobe frees the entry, so it is not an error.
    always_comb begin
        err_evt[1] = rx_push_ser_i && (rx_count_i == FULL_CNT)  && !rx_pop_bus_i;
        err_evt[0] = tx_pop_ser_i  && (tx_count_i == EMPTY_CNT) && !tx_push_bus_i;
        err_clr    = {NERR{clr_we_i}} & clr_bits_i;
    end

    generate
        for (genvar gi = 0; gi < NERR; gi++) begin : g_err
            afs_sticky u_sticky (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (err_evt[gi]),
                .clr_i  (err_clr[gi]),
                .flag_o (err_flag[gi])
            );
        end
    endgenerate

    afs_threshold #(.CNT_W(CNT_W), .TH_W(TH_W), .ABOVE(1'b1)) u_rx_th (
        .enable_i (enable_i),
        .count_i  (rx_count_i),
        .thresh_i (rx_thresh_i),
        .req_o    (rx_req_d)
    );

    afs_threshold #(.CNT_W(CNT_W), .TH_W(TH_W), .ABOVE(1'b0)) u_tx_th (
        .enable_i (enable_i),
        .count_i  (tx_count_i),
        .thresh_i (tx_thresh_i),
        .req_o    (tx_req_d)
    );

    // Assemble the next value of the level-driven fields.
    always_comb begin
        base_d                               = '0;
        base_d[RXLVL_LO +: LVL_W]            = rx_count_i[LVL_W-1:0];
        base_d[TXLVL_LO +: LVL_W]            = tx_count_i[LVL_W-1:0];
        base_d[B_RXREQ]                      = rx_req_d;
        base_d[B_TXREQ]                      = tx_req_d;
        base_d[B_BUSY]                       = enable_i && frame_active_i;
        base_d[B_RXNE]                       = (rx_count_i != EMPTY_CNT);
        base_d[B_TXNF]                       = (tx_count_i != FULL_CNT);
    end

    // Register the level-driven fields once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) base_q <= STW'(1);
        else        base_q <= base_d;
    end

    // Merge the sticky flags into the visible word.
    always_comb begin
        status_o          = base_q;
        status_o[B_OVER]  = err_flag[1];
        status_o[B_UNDER] = err_flag[0];
    end

    // Masked interrupt and unmasked DMA requests.
    always_comb begin
        irq_o        = |(status_o[B_OVER:B_TXREQ] & irq_mask_i);
        rx_dma_req_o = status_o[B_RXREQ];
        tx_dma_req_o = status_o[B_TXREQ];
    end

    // R7 / R8 / R9: requests and busy are low one clock after a disabled cycle
    a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (!status_o[B_RXREQ] && !status_o[B_TXREQ] && !status_o[B_BUSY]));
    // R3: a full transmit FIFO shows not-full low on the next clock
    a_r3_full_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count_i == FULL_CNT) |=> !status_o[B_TXNF]);
    // R2: level fields follow the counts with one clock of lag
    a_r2_levels: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status_o[RXLVL_LO +: LVL_W] == $past(rx_count_i[LVL_W-1:0])));
    // R4: an overrun event is visible on the next clock
    a_r4_overrun_seen: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push_ser_i && rx_count_i == FULL_CNT && !rx_pop_bus_i) |=> status_o[B_OVER]);
endmodule

// File: tb/audio_fifo_status_tb_top.sv
module audio_fifo_status_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable_i = 1'b0;
    logic        frame_active_i = 1'b0;
    logic [4:0]  rx_count_i = '0;
    logic [4:0]  tx_count_i = '0;
    logic        rx_push_ser_i = 1'b0;
    logic        rx_pop_bus_i = 1'b0;
    logic        tx_push_bus_i = 1'b0;
    logic        tx_pop_ser_i = 1'b0;
    logic [3:0]  rx_thresh_i = '0;
    logic [3:0]  tx_thresh_i = '0;
    logic [3:0]  irq_mask_i = '0;
    logic        clr_we_i = 1'b0;
    logic [1:0]  clr_bits_i = '0;
    logic [31:0] status_o;
    logic        irq_o;
    logic        rx_dma_req_o;
    logic        tx_dma_req_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    audio_fifo_status dut_i (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .frame_active_i(frame_active_i),
        .rx_count_i(rx_count_i), .tx_count_i(tx_count_i),
        .rx_push_ser_i(rx_push_ser_i), .rx_pop_bus_i(rx_pop_bus_i),
        .tx_push_bus_i(tx_push_bus_i), .tx_pop_ser_i(tx_pop_ser_i),
        .rx_thresh_i(rx_thresh_i), .tx_thresh_i(tx_thresh_i),
        .irq_mask_i(irq_mask_i), .clr_we_i(clr_we_i), .clr_bits_i(clr_bits_i),
        .status_o(status_o), .irq_o(irq_o),
        .rx_dma_req_o(rx_dma_req_o), .tx_dma_req_o(tx_dma_req_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Advance one edge and settle away from it.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Expected word from the requirements (R2, R3, R7, R8, R9; flags passed in).
    function automatic logic [31:0] exp_word(int rx, int tx, int rth, int tth,
                                             bit en, bit fr, bit ovr, bit und);
        logic [31:0] w = '0;
        w[15:12] = 4'(rx % 16);
        w[11:8]  = 4'(tx % 16);
        w[6]     = ovr;
        w[5]     = und;
        w[4]     = en && (rx >= rth + 1);
        w[3]     = en && (tx <= tth);
        w[2]     = en && fr;
        w[1]     = (rx != 0);
        w[0]     = (tx != 16);
        return w;
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=running expected=done");
        summary();
    end

    initial begin
        logic [31:0] w;
        step();
        step();
        // R1: reset state
        check(status_o, 32'h1, "R1 word");
        check({29'd0, irq_o, rx_dma_req_o, tx_dma_req_o}, 32'd0, "R1 outputs");
        rst_n = 1'b1;

        // Sweep of levels, thresholds, enable and busy (R2 R3 R7 R8 R9 R11).
        for (int en = 0; en < 2; en++) begin
            for (int th = 0; th < 16; th++) begin
                for (int c = 0; c <= 16; c++) begin
                    enable_i       = en[0];
                    frame_active_i = c[0];
                    rx_count_i     = 5'(c);
                    tx_count_i     = 5'(16 - c);
                    rx_thresh_i    = 4'(th);
                    tx_thresh_i    = 4'(15 - th);
                    step();
                    w = exp_word(c, 16 - c, th, 15 - th, en[0], c[0], 1'b0, 1'b0);
                    check(status_o, w, "R2 R3 R7 R8 R9 sweep");
                    check({30'd0, rx_dma_req_o, tx_dma_req_o}, {30'd0, w[4], w[3]}, "R11 dma");
                end
            end
        end

        // Overrun only at full, and not with a same-cycle bus pop (R4).
        enable_i = 1'b0; frame_active_i = 1'b0;
        rx_count_i = 5'd15; rx_push_ser_i = 1'b1; step(); rx_push_ser_i = 1'b0;
        check(32'(status_o[6]), 32'd0, "R4 no overrun at 15");
        rx_count_i = 5'd16; rx_push_ser_i = 1'b1; rx_pop_bus_i = 1'b1; step();
        rx_push_ser_i = 1'b0; rx_pop_bus_i = 1'b0;
        check(32'(status_o[6]), 32'd0, "R4 no overrun with bus pop");
        rx_push_ser_i = 1'b1; step(); rx_push_ser_i = 1'b0;
        check(32'(status_o[6]), 32'd1, "R4 overrun set");
        rx_count_i = 5'd3;
        for (int k = 0; k < 5; k++) step();
        check(32'(status_o[6]), 32'd1, "R4 overrun sticky");

        // Underrun only at empty, and not with a same-cycle bus push (R5).
        tx_count_i = 5'd1; tx_pop_ser_i = 1'b1; step(); tx_pop_ser_i = 1'b0;
        check(32'(status_o[5]), 32'd0, "R5 no underrun at 1");
        tx_count_i = 5'd0; tx_pop_ser_i = 1'b1; tx_push_bus_i = 1'b1; step();
        tx_pop_ser_i = 1'b0; tx_push_bus_i = 1'b0;
        check(32'(status_o[5]), 32'd0, "R5 no underrun with bus push");
        tx_pop_ser_i = 1'b1; step(); tx_pop_ser_i = 1'b0;
        check(32'(status_o[5]), 32'd1, "R5 underrun set");
        for (int k = 0; k < 5; k++) step();
        check(32'(status_o[5]), 32'd1, "R5 underrun sticky");

        // Clears are per bit; set wins over clear (R6).
        clr_we_i = 1'b1; clr_bits_i = 2'b10; step(); clr_we_i = 1'b0; clr_bits_i = 2'b00;
        check(32'(status_o[6:5]), 32'b01, "R6 clear overrun only");
        clr_we_i = 1'b1; clr_bits_i = 2'b01; tx_pop_ser_i = 1'b1; step();
        clr_we_i = 1'b0; clr_bits_i = 2'b00; tx_pop_ser_i = 1'b0;
        check(32'(status_o[6:5]), 32'b01, "R6 set wins over clear");
        clr_we_i = 1'b1; clr_bits_i = 2'b01; step(); clr_we_i = 1'b0; clr_bits_i = 2'b00;
        check(32'(status_o[6:5]), 32'b00, "R6 clear underrun");
        clr_we_i = 1'b1; clr_bits_i = 2'b11; step(); clr_we_i = 1'b0; clr_bits_i = 2'b00;
        check(32'(status_o[6:5]), 32'b00, "R6 clear of clear flags");

        // Interrupt masking with all four sources active (R10, R11).
        enable_i = 1'b1; rx_thresh_i = 4'd0; tx_thresh_i = 4'd0;
        rx_count_i = 5'd16; rx_push_ser_i = 1'b1;
        tx_count_i = 5'd0;  tx_pop_ser_i = 1'b1;
        step(); rx_push_ser_i = 1'b0; tx_pop_ser_i = 1'b0;
        check(32'(status_o[6:3]), 32'hF, "R10 all sources set");
        for (int m = 0; m < 16; m++) begin
            irq_mask_i = 4'(m);
            #1;
            check(32'(irq_o), 32'(m != 0), "R10 mask sweep");
            check({30'd0, rx_dma_req_o, tx_dma_req_o}, 32'b11, "R11 dma ignores mask");
        end
        // Only the transmit request remains.
        clr_we_i = 1'b1; clr_bits_i = 2'b11; rx_count_i = 5'd0; step();
        clr_we_i = 1'b0; clr_bits_i = 2'b00;
        for (int m = 0; m < 16; m++) begin
            irq_mask_i = 4'(m);
            #1;
            check(32'(irq_o), 32'(m[0]), "R10 tx request only");
        end
        check({30'd0, rx_dma_req_o, tx_dma_req_o}, 32'b01, "R11 dma tx only");

        // Disable drops the requests (R7 R8).
        enable_i = 1'b0; step();
        check(32'(irq_o), 32'd0, "R8 disabled request low");

        summary();
    end
endmodule